// File: doc/BRIEF.md
# Dual Cascadable Interval Timer

This block holds two down-counting interval timers, each 8 bits wide by default, that share one control word. Every timer has four settings: a reload divider, a run/stop-and-load mode bit, a two-bit clock source choice and a one-shot interrupt acknowledge bit. While stopped, a timer is held at its divider value. While running, it counts down by one on each strobe from its chosen source. When a strobe arrives at a count of one, the timer reloads its divider and latches a sticky interrupt flag.

The clock sources arrive as single-cycle enable strobes in the system clock domain: two base ticks and one external strobe. The second timer can also be clocked by the underflow pulse of the first timer. This chains the two into one longer timer. Software reads both counts and both flags at any time through a flat read word, so the elapsed ticks within a period equal the divider minus the count. Each interrupt output is the timer's flag gated by a mask input.

Top module: `dual_itimer`

## Requirements
- R1: While reset is asserted and after it is released with no write, the read word is all zero and both interrupt outputs are low.
- R2: Control word layout per timer `i` (field base `12*i`): divider in bits [7:0], run bit in bit 8 (0 = stop-and-load, 1 = run), source select in bits [10:9], acknowledge in bit 11. A write takes effect at the clock edge of the write. While the run bit is 0, the count equals the divider one cycle later.
- R3: While running, the count drops by one on each cycle with a strobe from the selected source and holds on every other cycle, so the elapsed ticks equal divider minus count.
- R4: A strobe at a count of one reloads the divider and sets the flag at the same edge. A divider of 0 acts as 256 (0 steps to 255). A 250 divider on a strobe every 10 cycles gives one underflow per 2500 cycles, and a 192 divider on a strobe every 13 cycles gives one underflow per 2496 cycles.
- R5: Source select encoding: 0 = base tick A, 1 = base tick B, 2 = external strobe, 3 = cascade. Strobes from unselected sources have no effect. On timer 0, code 3 never advances the count.
- R6: With cascade selected, timer 1 steps in the same cycle that timer 0 underflows.
- R7: A write with the acknowledge bit at 1 clears that timer's flag and leaves the other timer's flag alone. A write with it at 0 leaves the flag unchanged. The flag stays set until it is cleared.
- R8: An underflow in the same cycle as a clearing write leaves the flag set.
- R9: `irq[i]` equals flag `i` AND `irq_mask[i]`.
- R10: Read word layout: bits [7:0] count of timer 0, [15:8] count of timer 1, bit 16 flag 0, bit 17 flag 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_a | input | 1 | Base tick A strobe |
| tick_b | input | 1 | Base tick B strobe |
| tick_ext | input | 1 | External strobe |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 24 | Control word |
| irq_mask | input | 2 | Per-timer interrupt mask |
| rd_data | output | 18 | Counts and flags |
| irq | output | 2 | Masked interrupt requests |

## Verification
Two events can land in the same cycle: a timer underflow setting its flag and a control write clearing that flag. The same holds for a timer 0 underflow and the timer 1 step it drives in cascade. A directed case steps a timer to a count of one, then issues the final strobe and an acknowledging write in the same cycle, and expects the flag to remain set. The random phase uses short dividers, frequent strobes and frequent acknowledge writes, so that both collisions occur many times. Every cycle is judged against a cycle model in the bench that applies the priority stated in the requirements.

// File: rtl/itimer_pkg.sv
package itimer_pkg;

    // Clock source codes held in each timer's select field
    typedef enum logic [1:0] {
        SRC_TICK_A  = 2'd0,
        SRC_TICK_B  = 2'd1,
        SRC_EXT     = 2'd2,
        SRC_CASCADE = 2'd3
    } itimer_src_e;

endpackage

// File: rtl/itimer_srcsel.sv
module itimer_srcsel
    import itimer_pkg::*;
(
    input  itimer_src_e sel_i,
    input  logic        tick_a_i,
    input  logic        tick_b_i,
    input  logic        tick_ext_i,
    input  logic        casc_i,
    output logic        tick_o
);

    always_comb begin
        unique case (sel_i)
            SRC_TICK_A:  tick_o = tick_a_i;
            SRC_TICK_B:  tick_o = tick_b_i;
            SRC_EXT:     tick_o = tick_ext_i;
            default:     tick_o = casc_i;
        endcase
    end

endmodule

// File: rtl/itimer_chan.sv
module itimer_chan #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] div_i,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o,
    output logic             ufl_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     ufl;

    always_comb begin
        st_d = st_q;
        ufl  = run_i && tick_i && (st_q.cnt == ONE);
        if (!run_i) begin
            st_d.cnt = div_i;
        end else if (tick_i) begin
            // a zero divider wraps through all-ones, giving 2**CNT_W ticks
            st_d.cnt = ufl ? div_i : st_q.cnt - ONE;
        end
        // underflow wins over a same-cycle acknowledge
        if (ufl) begin
            st_d.flag = 1'b1;
        end else if (clr_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign flag_o = st_q.flag;
    assign ufl_o  = ufl;

    AST_STOP_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (st_q.cnt == $past(div_i)));                       // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i) |=> $stable(st_q.cnt));                    // R3
    AST_UFL_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ufl |=> (st_q.cnt == $past(div_i)));                          // R4
    AST_UFL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ufl |=> st_q.flag);                                           // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !clr_i) |=> st_q.flag);                         // R7

endmodule

// File: rtl/dual_itimer.sv
module dual_itimer
    import itimer_pkg::*;
#(
    parameter  int N_TMR  = 2,
    parameter  int CNT_W  = 8,
    localparam int FLD_W  = CNT_W + 4,
    localparam int CTRL_W = N_TMR * FLD_W,
    localparam int RD_W   = N_TMR * (CNT_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_a,
    input  logic              tick_b,
    input  logic              tick_ext,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic [N_TMR-1:0]  irq_mask,
    output logic [RD_W-1:0]   rd_data,
    output logic [N_TMR-1:0]  irq
);

    localparam int RUN_BIT = CNT_W;
    localparam int SEL_LSB = CNT_W + 1;
    localparam int ACK_BIT = CNT_W + 3;

    typedef struct packed {
        logic [CNT_W-1:0] div;
        logic             run;
        itimer_src_e      sel;
    } cfg_t;

    cfg_t             cfg_d [N_TMR];
    cfg_t             cfg_q [N_TMR];
    logic [N_TMR-1:0] clr;
    logic [N_TMR-1:0] tick;
    logic [N_TMR-1:0] ufl;
    logic [N_TMR-1:0] casc;
    logic [N_TMR-1:0] flag;
    logic [CNT_W-1:0] cnt [N_TMR];

    // next configuration; the acknowledge bit is an action, never stored
    always_comb begin
        for (int i = 0; i < N_TMR; i++) begin
            cfg_d[i] = cfg_q[i];
            clr[i]   = wr_en && wr_data[i*FLD_W + ACK_BIT];
            if (wr_en) begin
                cfg_d[i].div = wr_data[i*FLD_W +: CNT_W];
                cfg_d[i].run = wr_data[i*FLD_W + RUN_BIT];
                cfg_d[i].sel = itimer_src_e'(wr_data[i*FLD_W + SEL_LSB +: 2]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_TMR; i++) begin
                cfg_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N_TMR; i++) begin
                cfg_q[i] <= cfg_d[i];
            end
        end
    end

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        if (g == 0) begin : g_head
            assign casc[g] = 1'b0;
        end else begin : g_link
            assign casc[g] = ufl[g-1];

            AST_CASCADE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_q[g].run && cfg_q[g].sel == SRC_CASCADE && ufl[g-1]
                 && cnt[g] != CNT_W'(1))
                |=> (cnt[g] == $past(cnt[g]) - CNT_W'(1)));           // R6
        end

        itimer_srcsel i_srcsel (
            .sel_i      (cfg_q[g].sel),
            .tick_a_i   (tick_a),
            .tick_b_i   (tick_b),
            .tick_ext_i (tick_ext),
            .casc_i     (casc[g]),
            .tick_o     (tick[g])
        );

        itimer_chan #(.CNT_W(CNT_W)) i_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .div_i  (cfg_q[g].div),
            .run_i  (cfg_q[g].run),
            .tick_i (tick[g]),
            .clr_i  (clr[g]),
            .cnt_o  (cnt[g]),
            .flag_o (flag[g]),
            .ufl_o  (ufl[g])
        );

        assign rd_data[g*CNT_W +: CNT_W]  = cnt[g];
        assign rd_data[N_TMR*CNT_W + g]   = flag[g];
        assign irq[g]                     = flag[g] & irq_mask[g];
    end

endmodule

// File: tb/test_dual_itimer.sv
`timescale 1ns/1ps
module test_dual_itimer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_a = 1'b0, tick_b = 1'b0, tick_ext = 1'b0;
    logic        wr_en = 1'b0;
    logic [23:0] wr_data = '0;
    logic [1:0]  irq_mask = '0;
    logic [17:0] rd_data;
    logic [1:0]  irq;

    int n_checks = 0;
    int n_errors = 0;

    // cycle model state
    logic [7:0] m_div [2];
    logic       m_run [2];
    logic [1:0] m_sel [2];
    logic [7:0] m_cnt [2];
    logic       m_flag[2];

    always #2 clk = ~clk;

    dual_itimer i_dual_itimer (
        .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
        .tick_ext(tick_ext), .wr_en(wr_en), .wr_data(wr_data),
        .irq_mask(irq_mask), .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [11:0] fld(input logic [7:0] d, input logic r,
                                        input logic [1:0] s, input logic a);
        return {a, s, r, d};
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic model_step(input logic w, input logic [23:0] d,
                              input logic a, input logic b, input logic e);
        logic prev_ufl = 1'b0;
        for (int i = 0; i < 2; i++) begin
            logic t;
            logic u;
            case (m_sel[i])
                2'd0: t = a;
                2'd1: t = b;
                2'd2: t = e;
                default: t = (i > 0) ? prev_ufl : 1'b0;
            endcase
            u = m_run[i] && t && (m_cnt[i] == 8'd1);
            if (!m_run[i]) m_cnt[i] = m_div[i];
            else if (t) m_cnt[i] = u ? m_div[i] : m_cnt[i] - 8'd1;
            if (u) m_flag[i] = 1'b1;
            else if (w && d[i*12+11]) m_flag[i] = 1'b0;
            prev_ufl = u;
        end
        if (w) begin
            for (int i = 0; i < 2; i++) begin
                m_div[i] = d[i*12 +: 8];
                m_run[i] = d[i*12+8];
                m_sel[i] = d[i*12+9 +: 2];
            end
        end
    endtask

    // one clock: compare state, drive new inputs, advance model
    task automatic cycle(input logic w, input logic [23:0] d,
                         input logic a, input logic b, input logic e);
        @(negedge clk);
        chk("R10 count0", rd_data[7:0], m_cnt[0]);
        chk("R10 count1", rd_data[15:8], m_cnt[1]);
        chk("R7 flag0", rd_data[16], m_flag[0]);
        chk("R7 flag1", rd_data[17], m_flag[1]);
        chk("R9 irq", irq, {m_flag[1] & irq_mask[1], m_flag[0] & irq_mask[0]});
        wr_en = w; wr_data = d; tick_a = a; tick_b = b; tick_ext = e;
        model_step(w, d, a, b, e);
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 4);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int t0_last, t1_last, t0_n, t1_n;
        logic [23:0] rate_cfg;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 2; i++) begin
            m_div[i] = '0; m_run[i] = 1'b0; m_sel[i] = '0;
            m_cnt[i] = '0; m_flag[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset read word", rd_data, 0);
        chk("R1 reset irq", irq, 0);
        @(negedge clk);
        rst_n = 1'b1;
        irq_mask = 2'b11;
        cycle(0, '0, 0, 0, 0);
        settle();
        chk("R1 idle after reset", rd_data, 0);

        // R4: divider 0 behaves as 256
        cycle(1, {fld(0, 0, 0, 0), fld(0, 0, 0, 0)}, 0, 0, 0);
        cycle(1, {fld(0, 0, 0, 0), fld(0, 1, 0, 0)}, 0, 0, 0);
        cycle(0, '0 | {fld(0, 0, 0, 0), fld(0, 1, 0, 0)}, 0, 0, 0);
        cycle(0, '0, 1, 0, 0);
        settle();
        chk("R4 zero divider steps to 255", rd_data[7:0], 255);

        // R2: stop-and-load presets the divider
        cycle(1, {fld(0, 0, 0, 0), fld(5, 0, 0, 0)}, 1, 0, 0);
        cycle(0, '0, 1, 0, 0);
        settle();
        chk("R2 stop loads divider", rd_data[7:0], 5);

        // R3/R5: run on tick A, other strobes ignored
        cycle(1, {fld(0, 0, 0, 0), fld(5, 1, 0, 0)}, 0, 0, 0);
        cycle(0, '0, 0, 1, 1);
        settle();
        chk("R5 unselected strobes ignored", rd_data[7:0], 5);
        cycle(0, '0, 1, 0, 0);
        settle();
        chk("R3 decrement", rd_data[7:0], 4);
        chk("R3 elapsed = div - count", 5 - rd_data[7:0], 1);
        cycle(1, {fld(0, 0, 0, 0), fld(5, 1, 2, 0)}, 0, 0, 0);
        cycle(0, '0, 1, 1, 1);
        settle();
        chk("R5 external select", rd_data[7:0], 3);
        cycle(1, {fld(0, 0, 0, 0), fld(5, 1, 3, 0)}, 0, 0, 0);
        cycle(0, '0, 1, 1, 1);
        settle();
        chk("R5 cascade code on timer 0 holds", rd_data[7:0], 3);

        // R6: cascade chain
        cycle(1, {fld(3, 0, 3, 1), fld(1, 0, 0, 1)}, 0, 0, 0);
        cycle(1, {fld(3, 1, 3, 0), fld(1, 1, 0, 0)}, 0, 0, 0);
        cycle(0, '0, 1, 0, 0);
        settle();
        chk("R6 timer1 steps on timer0 underflow", rd_data[15:8], 2);
        chk("R4 underflow sets flag0", rd_data[16], 1);
        cycle(0, '0, 1, 0, 0);
        cycle(0, '0, 1, 0, 0);
        settle();
        chk("R6 timer1 reloads", rd_data[15:8], 3);
        chk("R6 timer1 flag", rd_data[17], 1);

        // R9: masking
        irq_mask = 2'b01;
        cycle(0, '0, 0, 0, 0);
        settle();
        chk("R9 masked irq", irq, 2'b01);
        irq_mask = 2'b11;

        // R7: acknowledge timer 0 only, stopped config
        cycle(1, {fld(3, 0, 3, 0), fld(1, 0, 0, 1)}, 0, 0, 0);
        settle();
        chk("R7 ack clears flag0", rd_data[16], 0);
        chk("R7 other flag kept", rd_data[17], 1);
        cycle(1, {fld(3, 0, 3, 0), fld(1, 0, 0, 0)}, 0, 0, 0);
        settle();
        chk("R7 nop ack keeps flag1", rd_data[17], 1);

        // R8: underflow and clear in the same cycle
        cycle(1, {fld(3, 0, 3, 1), fld(2, 0, 0, 1)}, 0, 0, 0);
        cycle(1, {fld(3, 0, 3, 0), fld(2, 1, 0, 0)}, 0, 0, 0);
        cycle(0, '0, 1, 0, 0);
        settle();
        chk("R8 pre-collision count", rd_data[7:0], 1);
        chk("R8 pre-collision flag", rd_data[16], 0);
        cycle(1, {fld(3, 0, 3, 0), fld(2, 1, 0, 1)}, 1, 0, 0);
        settle();
        chk("R8 underflow beats clear", rd_data[16], 1);
        chk("R4 reload on underflow", rd_data[7:0], 2);

        // R4: 100 Hz rates from both tick/divider pairs
        rate_cfg = {fld(192, 1, 1, 0), fld(250, 1, 0, 0)};
        cycle(1, {fld(192, 0, 1, 1), fld(250, 0, 0, 1)}, 0, 0, 0);
        cycle(1, rate_cfg, 0, 0, 0);
        t0_last = -1; t1_last = -1; t0_n = 0; t1_n = 0;
        for (int c = 0; c < 8000; c++) begin
            logic [23:0] d;
            logic w;
            settle();
            d = rate_cfg;
            w = 1'b0;
            if (rd_data[16]) begin
                if (t0_last >= 0) begin
                    chk("R4 period 250 x 10", c - t0_last, 2500);
                    t0_n++;
                end
                t0_last = c; d[11] = 1'b1; w = 1'b1;
            end
            if (rd_data[17]) begin
                if (t1_last >= 0) begin
                    chk("R4 period 192 x 13", c - t1_last, 2496);
                    t1_n++;
                end
                t1_last = c; d[23] = 1'b1; w = 1'b1;
            end
            cycle(w, d, (c % 10) == 0, (c % 13) == 0, 1'b0);
        end
        chk("R4 timer0 periods seen", t0_n, 2);
        chk("R4 timer1 periods seen", t1_n, 2);

        // random phase against the model
        for (int c = 0; c < 20000; c++) begin
            logic [23:0] d;
            for (int i = 0; i < 2; i++) begin
                logic [7:0] dv;
                dv = (($urandom % 4) == 0) ? 8'd0 : 8'(1 + $urandom % 5);
                d[i*12 +: 12] = fld(dv, ($urandom % 4) != 0, 2'($urandom),
                                    ($urandom % 3) == 0);
            end
            if (($urandom % 64) == 0) irq_mask = 2'($urandom);
            cycle(($urandom % 12) == 0, d, $urandom % 2, $urandom % 2, $urandom % 2);
        end
        cycle(0, '0, 0, 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule